// File: doc/BRIEF.md
# Priority Interrupt Collector

The collector merges a bank of level-sensitive interrupt request lines into one processor interrupt output. Each source has an enable bit and a priority level. When requests arrive, the collector chooses one, latches its number and raises the processor request. Software then reads the chosen source number from a status register.

Service takes two writes. A write of any value to the vector register drops the processor request and marks the level of that request as in service. While a level is in service, only sources at a strictly higher level can raise a new request. A one-hot write to the level-acknowledge register takes a level out of service. Per-source registers and the control register have set and clear aliases, so single bits can change without a read-modify-write.

The control register also holds a soft-reset bit and a clock-gate bit. While soft reset is set, all configuration is wiped and the gate bit is forced on. Software then releases the block and clears the gate.

Top module: `irq_collector`

## Requirements
- R1: The register for source n is at byte address 0x100 + n*0x10. Bit 4 is the enable bit and bits 1:0 are the priority. A write at that address replaces both fields and a read returns them. A disabled source never raises the request.
- R2: Address +0x4 from a per-source or control register is a set alias and +0x8 is a clear alias. A 1 in the written data sets (or clears) that bit, and bits written 0 keep their value.
- R3: When the request is idle and an enabled source input is high, `cpu_irq` rises at the next clock edge. The status register (address 0x010, bits 6:0) then holds that source number.
- R4: Among eligible sources the highest priority wins, and a tie goes to the lowest source number.
- R5: The status vector reads 0x7F whenever no request is outstanding, including after reset.
- R6: A write of any data to the vector register (0x020) while the request is high drops `cpu_irq` at that edge and marks the latched level as in service.
- R7: While any level is in service, only a source whose priority is strictly above the highest in-service level can raise the request.
- R8: Writing the level-acknowledge register (0x030) with bit L set takes level L out of service.
- R9: Once latched, the request and its vector stay unchanged until the vector write, even if a higher-priority source arrives or the source input falls.
- R10: Control register (0x000): bit 1 is soft reset and bit 0 is clock gate. While soft reset is set the gate bit reads 1. After soft reset is cleared, the gate reads 1 until software clears it.
- R11: Soft reset clears every enable bit, every priority and every in-service level. It also drops `cpu_irq`, so the status reads 0x7F.
- R12: While the clock-gate bit is set, no new request is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | NUM_SRC | Level interrupt inputs, one per source |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The bench uses the default of 127 sources with 2-bit priorities. With these values, source 126, the top legal number, sits at the highest register address and can win arbitration. All four levels can also be put in service and acknowledged one at a time. The directed scenarios cover ties, requests blocked by equal and lower in-service levels, preemption by a strictly higher level, and a soft reset that wipes a level still in service.

// File: rtl/irq_collector.sv
module irq_collector #(
  parameter int NUM_SRC = 127,
  parameter int PRIO_W  = 2,
  parameter int ADDR_W  = $clog2(256 + NUM_SRC * 16)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               cpu_irq
);
  localparam int LEVELS = 1 << PRIO_W;
  localparam int IDX_W  = $clog2(NUM_SRC);
  localparam int GRP_W  = ADDR_W - 4;
  localparam int EN_BIT = 4;
  localparam logic [6:0]       NO_VEC   = 7'h7F;
  localparam logic [GRP_W-1:0] GRP_CTRL = GRP_W'(0);
  localparam logic [GRP_W-1:0] GRP_STAT = GRP_W'(1);
  localparam logic [GRP_W-1:0] GRP_VEC  = GRP_W'(2);
  localparam logic [GRP_W-1:0] GRP_ACK  = GRP_W'(3);
  localparam logic [GRP_W-1:0] GRP_SRC  = GRP_W'(16);
  localparam logic [GRP_W-1:0] GRP_LIM  = GRP_W'(16 + NUM_SRC);

  logic [NUM_SRC-1:0] en;
  logic [PRIO_W-1:0]  prio [NUM_SRC];
  logic               srst_q, gate_q;
  logic [LEVELS-1:0]  ins, ins_nxt;
  logic [IDX_W-1:0]   cur_idx;
  logic [PRIO_W-1:0]  cur_lvl;

  logic [GRP_W-1:0] grp;
  logic [1:0]       sub;
  logic [GRP_W-1:0] sidx_full;
  logic [IDX_W-1:0] sidx;
  logic             src_ok, ctrl_wr, src_wr, vec_wr, ack_wr;
  logic [31:0]      src_word, src_new, ctrl_word, ctrl_new;
  logic [6:0]       stat_vec;

  assign grp       = bus_addr[ADDR_W-1:4];
  assign sub       = bus_addr[3:2];
  assign sidx_full = grp - GRP_SRC;
  assign sidx      = sidx_full[IDX_W-1:0];
  assign src_ok    = (grp >= GRP_SRC) && (grp < GRP_LIM);
  assign ctrl_wr   = bus_wr && grp == GRP_CTRL && sub != 2'd3;
  assign src_wr    = bus_wr && src_ok && sub != 2'd3;
  assign vec_wr    = bus_wr && grp == GRP_VEC && sub == 2'd0;
  assign ack_wr    = bus_wr && grp == GRP_ACK && sub == 2'd0;

  function automatic logic [31:0] apply(input logic [31:0] old, input logic [31:0] d,
                                        input logic [1:0] s);
    case (s)
      2'd0:    return d;
      2'd1:    return old | d;
      2'd2:    return old & ~d;
      default: return old;
    endcase
  endfunction

  always_comb begin
    src_word = '0;
    if (src_ok) begin
      src_word[EN_BIT]       = en[sidx];
      src_word[PRIO_W-1:0]   = prio[sidx];
    end
  end
  assign ctrl_word = {30'd0, srst_q, gate_q};
  assign src_new   = apply(src_word, bus_wdata, sub);
  assign ctrl_new  = apply(ctrl_word, bus_wdata, sub);

  logic              ins_any;
  logic [PRIO_W-1:0] ins_top;
  always_comb begin
    ins_any = |ins;
    ins_top = '0;
    for (int l = 0; l < LEVELS; l++)
      if (ins[l]) ins_top = PRIO_W'(l);
  end

  logic              win_ok;
  logic [IDX_W-1:0]  win_idx;
  logic [PRIO_W-1:0] win_lvl;
  always_comb begin
    win_ok  = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int n = 0; n < NUM_SRC; n++)
      if (src_irq[n] && en[n] && (!ins_any || prio[n] > ins_top) &&
          (!win_ok || prio[n] > win_lvl)) begin
        win_ok  = 1'b1;
        win_idx = IDX_W'(n);
        win_lvl = prio[n];
      end
  end

  always_comb begin
    ins_nxt = ins;
    if (ack_wr) ins_nxt = ins & ~bus_wdata[LEVELS-1:0];
    if (vec_wr && cpu_irq) ins_nxt[cur_lvl] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= '0;
      for (int n = 0; n < NUM_SRC; n++) prio[n] <= '0;
    end else if (srst_q) begin
      en <= '0;
      for (int n = 0; n < NUM_SRC; n++) prio[n] <= '0;
    end else if (src_wr) begin
      en[sidx]   <= src_new[EN_BIT];
      prio[sidx] <= src_new[PRIO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q  <= 1'b0;
      gate_q  <= 1'b0;
      ins     <= '0;
      cpu_irq <= 1'b0;
      cur_idx <= '0;
      cur_lvl <= '0;
    end else begin
      if (ctrl_wr) begin
        srst_q <= ctrl_new[1];
        gate_q <= ctrl_new[0];
      end
      if (srst_q) begin
        gate_q  <= 1'b1;
        ins     <= '0;
        cpu_irq <= 1'b0;
      end else begin
        ins <= ins_nxt;
        if (cpu_irq) begin
          if (vec_wr) cpu_irq <= 1'b0;
        end else if (win_ok && !gate_q) begin
          cpu_irq <= 1'b1;
          cur_idx <= win_idx;
          cur_lvl <= win_lvl;
        end
      end
    end
  end

  assign stat_vec = cpu_irq ? 7'(cur_idx) : NO_VEC;

  always_comb begin
    bus_rdata = '0;
    if (grp == GRP_CTRL && sub != 2'd3) bus_rdata = ctrl_word;
    else if (grp == GRP_STAT)           bus_rdata = {25'd0, stat_vec};
    else if (src_ok && sub != 2'd3)     bus_rdata = src_word;
  end
endmodule

module irq_collector_chk #(
  parameter int NUM_SRC = 127,
  parameter int LEVELS  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_irq,
  input logic [6:0]        stat_vec,
  input logic              srst_q,
  input logic              gate_q,
  input logic [LEVELS-1:0] ins,
  input logic              vec_wr
);
  p_vec_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> stat_vec < 7'(NUM_SRC));
  p_drop_on_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && vec_wr && !srst_q) |=> !cpu_irq);
  p_mark_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && vec_wr && !srst_q) |=> ins != '0);
  p_hold_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && $past(cpu_irq)) |-> $stable(stat_vec));
  p_gate_forced_r10: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> gate_q);
  p_srst_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (!cpu_irq && ins == '0));
  p_gate_blocks_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && !cpu_irq) |=> !cpu_irq);
endmodule

bind irq_collector irq_collector_chk #(.NUM_SRC(NUM_SRC), .LEVELS(LEVELS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_irq(cpu_irq), .stat_vec(stat_vec),
  .srst_q(srst_q), .gate_q(gate_q), .ins(ins), .vec_wr(vec_wr)
);

// File: tb/test_irq_collector.sv
module test_irq_collector;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_SRC = 127;
  localparam int ADDR_W = 12;

  logic clk = 0, rst_n = 0, bus_wr = 0, cpu_irq;
  logic [NUM_SRC-1:0] src_irq = '0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  irq_collector i_irq_collector (.clk(clk), .rst_n(rst_n), .src_irq(src_irq),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [ADDR_W-1:0] sreg(input int n, input int alias_off);
    return ADDR_W'(256 + n * 16 + alias_off);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic settle(); repeat (3) @(negedge clk); endtask

  task automatic chk_stat(input string req, input logic irq, input logic [31:0] vec);
    logic [31:0] d;
    rd(12'h010, d);
    chk(req, {31'd0, cpu_irq}, {31'd0, irq});
    chk(req, d, vec);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk_stat("R5 reset", 0, 32'h7F);
    rd(12'h000, d); chk("R10 reset ctrl", d, 0);
    rd(sreg(0, 0), d); chk("R1 reset src", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(sreg(5, 0), 32'h13); rd(sreg(5, 0), d); chk("R1 write/read", d, 32'h13);
    wr(sreg(5, 8), 32'h01); rd(sreg(5, 0), d); chk("R2 clear alias", d, 32'h12);
    wr(sreg(5, 4), 32'h01); rd(sreg(5, 0), d); chk("R2 set alias", d, 32'h13);
    wr(sreg(126, 4), 32'h10); rd(sreg(126, 0), d); chk("R2 set top source", d, 32'h10);
    wr(sreg(5, 0), 0); wr(sreg(126, 0), 0);
  endtask

  task automatic t_single();
    wr(sreg(9, 0), 32'h11);
    src_irq[9] = 1; settle();
    chk_stat("R3 single", 1, 9);
    wr(12'h020, 32'hDEAD);
    chk("R6 drop", {31'd0, cpu_irq}, 0);
    settle(); chk_stat("R7 same level blocked", 0, 32'h7F);
    wr(12'h030, 32'h2); settle();
    chk_stat("R8 ack reopens", 1, 9);
    src_irq[9] = 0; settle();
    chk_stat("R9 held after input falls", 1, 9);
    wr(12'h020, 0); wr(12'h030, 32'h2); settle();
    chk_stat("R5 idle", 0, 32'h7F);
    wr(sreg(9, 0), 0);
  endtask

  task automatic t_arb();
    wr(sreg(20, 0), 32'h12); wr(sreg(30, 0), 32'h12);
    wr(sreg(10, 0), 32'h11); wr(sreg(126, 0), 32'h03);
    src_irq[20] = 1; src_irq[30] = 1; src_irq[10] = 1; src_irq[126] = 1;
    settle(); chk_stat("R4 priority and tie", 1, 20);
    wr(12'h020, 0); settle();
    chk_stat("R7 equal and lower blocked", 0, 32'h7F);
    chk_stat("R1 disabled ignored", 0, 32'h7F);
    wr(sreg(126, 4), 32'h10); settle();
    chk_stat("R7 strictly higher fires", 1, 126);
    wr(12'h020, 0); src_irq[126] = 0;
    wr(12'h030, 32'h8); settle();
    chk_stat("R8 level 2 still in service", 0, 32'h7F);
    wr(12'h030, 32'h4); settle();
    chk_stat("R8 level 2 acked", 1, 20);
    src_irq[20] = 0; src_irq[30] = 0; src_irq[10] = 0;
    wr(12'h020, 0); wr(12'h030, 32'hF);
    wr(sreg(20, 0), 0); wr(sreg(30, 0), 0); wr(sreg(10, 0), 0); wr(sreg(126, 0), 0);
    settle(); chk_stat("R5 idle after arb", 0, 32'h7F);
  endtask

  task automatic t_hold();
    wr(sreg(40, 0), 32'h10); wr(sreg(41, 0), 32'h13);
    src_irq[40] = 1; settle();
    chk_stat("R3 low level", 1, 40);
    src_irq[41] = 1; settle();
    chk_stat("R9 no preempt of latched", 1, 40);
    wr(12'h020, 0); settle();
    chk_stat("R7 higher after vector", 1, 41);
    src_irq[40] = 0; src_irq[41] = 0;
    wr(12'h020, 0); wr(12'h030, 32'h9);
    wr(sreg(40, 0), 0); wr(sreg(41, 0), 0); settle();
    chk_stat("R8 both acked", 0, 32'h7F);
  endtask

  task automatic t_gate_srst();
    logic [31:0] d;
    wr(12'h004, 32'h1); rd(12'h000, d); chk("R2 ctrl set gate", d, 1);
    wr(sreg(50, 0), 32'h11); src_irq[50] = 1; settle();
    chk_stat("R12 gate blocks", 0, 32'h7F);
    wr(12'h008, 32'h1); settle();
    chk_stat("R12 gate released", 1, 50);
    wr(12'h020, 0);
    wr(12'h004, 32'h2); settle();
    rd(12'h000, d); chk("R10 gate forced", d, 3);
    chk_stat("R11 quiet in soft reset", 0, 32'h7F);
    wr(12'h008, 32'h2); settle();
    rd(12'h000, d); chk("R10 gate held after release", d, 1);
    wr(12'h008, 32'h1); rd(12'h000, d); chk("R10 gate cleared", d, 0);
    rd(sreg(50, 0), d); chk("R11 config wiped", d, 0);
    chk_stat("R11 disabled after wipe", 0, 32'h7F);
    wr(sreg(50, 0), 32'h10); settle();
    chk_stat("R11 in-service wiped", 1, 50);
    src_irq[50] = 0; wr(12'h020, 0); wr(12'h030, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_regs(); t_single(); t_arb(); t_hold(); t_gate_srst();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule